// File: doc/BRIEF.md
# GPIO Pin Direction Register Bank

This block holds the direction settings for fourteen byte-wide general-purpose I/O ports, one bit per pin. A bit at 1 turns its pin into an output and a bit at 0 leaves it as an input. Software reaches the settings over a small byte bus. Each access carries a 10-bit address, a write strobe and write data. Read data comes back combinationally for the address currently on the bus. The block drives one output-enable line per pin (112 in all) toward the pad ring.

Several guards sit in front of the registers:
- Port 9 accepts a write only when that write immediately follows the arming of a one-shot unlock bit.
- While the external-bus mode input is high, the bits in a parameter mask hold their values. These bits belong to pins lent to the memory bus.
- One bit of port 8 does not exist. It always reads 0 and never enables its pin.
- Ports 11 to 13 form an upper group. That group drives only while a separate group enable bit is set.

Top module: `gpio_dir_bank`

## Requirements
- R1: After reset every port register, the unlock bit and the group enable bit read 0, and every bit of `pin_oe` is 0.
- R2: The port registers sit at byte addresses 0x3E2, 0x3E3, 0x3E6, 0x3E7, 0x3EA, 0x3EB, 0x3EE and 0x3EF for ports 0–7, 0x3F2 for port 8, 0x3F3, 0x3F6, 0x3F7 and 0x3FA for ports 9–12, and 0x3FB for port 13. A write stores the data byte, and a read at that address returns it.
- R3: Bit 5 of port 8 is unimplemented. It reads 0 whatever was written, and `pin_oe[69]` stays 0.
- R4: A write to port 9 (0x3F3) takes effect only if the unlock bit is 1 at that write. Otherwise the register keeps its value.
- R5: The unlock bit is bit 0 of address 0x3D0 and is readable there. Any bus write clears it, whatever the target address, unless that write puts 1 into bit 0 of 0x3D0.
- R6: While `ext_bus_mode` is 1, a write leaves the bits selected by `LOCK_MASK` unchanged and updates the other bits of the same byte. By default the mask covers all of ports 0 and 1 and bits 3:0 of port 4. While `ext_bus_mode` is 0, every implemented bit is writable.
- R7: For ports 11, 12 and 13, `pin_oe[8*p+b]` equals the direction bit AND the group enable, which is bit 0 of address 0x3D1. For all other ports, `pin_oe[8*p+b]` equals the direction bit.
- R8: A read of any other address returns 0x00. A write to any other address changes no register, apart from clearing the unlock bit.
- R9: `pin_oe` reflects a write on the clock edge that accepts it. Read data follows the current address and state with no added cycle.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ext_bus_mode | input | 1 | External-memory mode; locks masked bits |
| pin_oe | output | 112 | Per-pin output enable, bit 8*p+b for port p pin b |

## Verification
A wrong direction bit shows up twice. It appears on the matching `pin_oe` line right after the faulty write's clock edge, and it appears on `bus_rdata` as soon as that port's address is presented.

An unlock bit that fails to clear only becomes visible on a later port 9 write that should have been refused. For that reason the bench follows each armed write with a second port 9 write, and it also checks an unmapped write in between.

A lock mask or group gate that is wrong stays hidden until the mode input or the group bit changes. The tests therefore toggle both inputs and then read the same bytes back.

// File: rtl/gpio_dir_bank.sv
module gpio_dir_bank #(
  parameter logic [9:0]   PROT_ADDR = 10'h3D0,
  parameter logic [9:0]   GRP_ADDR  = 10'h3D1,
  parameter int           GRP_FIRST = 11,
  parameter logic [111:0] LOCK_MASK = 112'h0F0000FFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [9:0]   bus_addr,
  input  logic         bus_we,
  input  logic [7:0]   bus_wdata,
  output logic [7:0]   bus_rdata,
  input  logic         ext_bus_mode,
  output logic [111:0] pin_oe
);
  localparam int NPORT   = 14;
  localparam int NBITS   = NPORT * 8;
  localparam int GUARDED = 9;
  localparam int GAPPORT = 8;
  localparam int GAPBIT  = 5;
  localparam int GRPLO   = GRP_FIRST * 8;
  localparam logic [9:0] MAP [NPORT] = '{
    10'h3E2, 10'h3E3, 10'h3E6, 10'h3E7, 10'h3EA, 10'h3EB, 10'h3EE,
    10'h3EF, 10'h3F2, 10'h3F3, 10'h3F6, 10'h3F7, 10'h3FA, 10'h3FB};

  logic             prot_q, grp_q;
  logic [NBITS-1:0] dir_flat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      grp_q  <= 1'b0;
    end else if (bus_we) begin
      prot_q <= (bus_addr == PROT_ADDR) && bus_wdata[0];
      if (bus_addr == GRP_ADDR) grp_q <= bus_wdata[0];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [7:0] q, lock, nxt;
    logic       allow;
    localparam logic [7:0] GAP = (p == GAPPORT) ? (8'h01 << GAPBIT) : 8'h00;
    assign allow = (p == GUARDED) ? prot_q : 1'b1;
    assign lock  = ext_bus_mode ? LOCK_MASK[p*8 +: 8] : 8'h00;
    assign nxt   = ((q & lock) | (bus_wdata & ~lock)) & ~GAP;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= 8'h00;
      else if (bus_we && bus_addr == MAP[p] && allow) q <= nxt;
    end
    assign dir_flat[p*8 +: 8] = q;
    if (p >= GRP_FIRST) begin : g_grp
      assign pin_oe[p*8 +: 8] = q & {8{grp_q}};
    end else begin : g_plain
      assign pin_oe[p*8 +: 8] = q;
    end
  end

  logic hit;
  always_comb begin
    bus_rdata = 8'h00;
    hit = 1'b0;
    for (int p = 0; p < NPORT; p++)
      if (bus_addr == MAP[p]) begin
        bus_rdata = dir_flat[p*8 +: 8];
        hit = 1'b1;
      end
    if (bus_addr == PROT_ADDR) begin bus_rdata = {7'd0, prot_q}; hit = 1'b1; end
    if (bus_addr == GRP_ADDR)  begin bus_rdata = {7'd0, grp_q};  hit = 1'b1; end
  end

  assert_p9_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == MAP[GUARDED] && !prot_q) |=> $stable(dir_flat[GUARDED*8 +: 8]));

  assert_unlock_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !(bus_addr == PROT_ADDR && bus_wdata[0])) |=> (bus_rdata[0] == 1'b0 || bus_addr != PROT_ADDR));

  assert_locked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && ext_bus_mode) |=> ((dir_flat & LOCK_MASK) == $past(dir_flat & LOCK_MASK)));

  assert_group_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_q |-> (pin_oe[NBITS-1:GRPLO] == '0));

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (bus_rdata == 8'h00));
endmodule

// File: tb/test_gpio_dir_bank.sv
module test_gpio_dir_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [9:0]   addr = '0;
  logic         we = 1'b0;
  logic [7:0]   wd = '0;
  logic         ext = 1'b0;
  logic [7:0]   rd;
  logic [111:0] oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_dir_bank i_gpio_dir_bank (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wd), .bus_rdata(rd), .ext_bus_mode(ext), .pin_oe(oe));

  localparam logic [9:0] PORTA [14] = '{
    10'h3E2, 10'h3E3, 10'h3E6, 10'h3E7, 10'h3EA, 10'h3EB, 10'h3EE,
    10'h3EF, 10'h3F2, 10'h3F3, 10'h3F6, 10'h3F7, 10'h3FA, 10'h3FB};

  // {address, write data, expected read}
  localparam logic [25:0] VEC [15] = '{
    {10'h3E2, 8'hA5, 8'hA5}, {10'h3E3, 8'hFF, 8'hFF}, {10'h3E6, 8'h3C, 8'h3C},
    {10'h3E7, 8'h01, 8'h01}, {10'h3EA, 8'h80, 8'h80}, {10'h3EB, 8'h7E, 8'h7E},
    {10'h3EE, 8'h55, 8'h55}, {10'h3EF, 8'hAA, 8'hAA}, {10'h3F2, 8'hFF, 8'hDF},
    {10'h3F6, 8'h12, 8'h12}, {10'h3F7, 8'h34, 8'h34}, {10'h3FA, 8'hC3, 8'hC3},
    {10'h3FB, 8'h0F, 8'h0F}, {10'h3E4, 8'hFF, 8'h00}, {10'h3C5, 8'hFF, 8'h00}};

  task automatic chk(input string req, input logic [111:0] act, input logic [111:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wd = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [9:0] a, input logic [7:0] exp);
    addr = a; #1;
    chk(req, {104'd0, rd}, {104'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 14; i++) rdchk("R1 reset port", PORTA[i], 8'h00);
    rdchk("R1 reset unlock", 10'h3D0, 8'h00);
    rdchk("R1 reset group", 10'h3D1, 8'h00);
    chk("R1 reset oe", oe, '0);

    for (int i = 0; i < 15; i++) begin
      wr(VEC[i][25:16], VEC[i][15:8]);
      rdchk("R2/R3/R8 vector", VEC[i][25:16], VEC[i][7:0]);
    end
    chk("R9 port0 oe", {104'd0, oe[7:0]}, {104'd0, 8'hA5});
    chk("R3 port8 oe", {104'd0, oe[71:64]}, {104'd0, 8'hDF});
    chk("R7 group off", {88'd0, oe[111:88]}, '0);
    rdchk("R8 unmapped left ports", 10'h3E2, 8'hA5);

    wr(10'h3D1, 8'h01);
    chk("R7 group on", {88'd0, oe[111:88]}, {88'd0, 8'h0F, 8'hC3, 8'h34});
    chk("R7 port10 ungated", {104'd0, oe[87:80]}, {104'd0, 8'h12});

    wr(10'h3F3, 8'hFF);
    rdchk("R4 locked write", 10'h3F3, 8'h00);
    wr(10'h3D0, 8'h01);
    rdchk("R5 unlock reads 1", 10'h3D0, 8'h01);
    wr(10'h3F3, 8'h5A);
    rdchk("R4 unlocked write", 10'h3F3, 8'h5A);
    chk("R4 port9 oe", {104'd0, oe[79:72]}, {104'd0, 8'h5A});
    rdchk("R5 unlock consumed", 10'h3D0, 8'h00);
    wr(10'h3F3, 8'hFF);
    rdchk("R4 second write refused", 10'h3F3, 8'h5A);
    wr(10'h3D0, 8'h01);
    wr(10'h3C7, 8'h00);
    rdchk("R5 cleared by unmapped write", 10'h3D0, 8'h00);
    wr(10'h3F3, 8'h00);
    rdchk("R5 port9 stays", 10'h3F3, 8'h5A);

    ext = 1'b1;
    wr(10'h3E2, 8'h00);
    rdchk("R6 port0 locked", 10'h3E2, 8'hA5);
    wr(10'h3EA, 8'hFF);
    rdchk("R6 port4 partial", 10'h3EA, 8'hF0);
    wr(10'h3E6, 8'h99);
    rdchk("R6 port2 free", 10'h3E6, 8'h99);
    ext = 1'b0;
    wr(10'h3E2, 8'h00);
    rdchk("R6 unlocked again", 10'h3E2, 8'h00);
    chk("R9 oe follows", {104'd0, oe[7:0]}, '0);

    wr(10'h3D1, 8'h00);
    chk("R7 group off again", {88'd0, oe[111:88]}, '0);
    rdchk("R7 dir kept", 10'h3F7, 8'h34);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 second reset oe", oe, '0);
    rdchk("R1 second reset port9", 10'h3F3, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule